// File: doc/BRIEF.md
# Dual-Channel Programmable Interval Timer

This block provides two independent 16-bit interval timers on a simple word-oriented register bus. Both channels run from the same functional clock. Each channel scales that clock down on its own with a power-of-two divider, so each channel has its own tick rate.

Software writes a terminal value and then sets the run bit. The channel then counts up from zero, one step per tick. When the count reaches the terminal value, the channel latches a pending flag. In periodic mode it then wraps to zero and keeps going. In single-shot mode it stops and holds its count.

Each channel drives a level interrupt line. The line is high while the pending flag is set and interrupts are enabled for that channel. Software acknowledges the interrupt by writing a one to the flag.

Top module: `dual_interval_timer`

## Requirements
- R1: Channel c (0 or 1) has four registers at byte address 0x80*(c+1) plus an offset: 0x0 for control, 0x4 for status, 0x8 for terminal and 0xC for count. Any other address, including a misaligned one, reads as 0x0000, and a write to it changes nothing.
- R2: The control register fields are:
  - bit 8: interrupt enable.
  - bit 5: run.
  - bit 4: single-shot when 1, periodic when 0.
  - bits 3:0: divider code.
  - All other bits read as zero.
- R3: When a write takes the run bit from 0 to 1, the count becomes 0 and the divider restarts. While the channel runs, the count then rises by one on each tick.
- R4: With divider code n, a tick occurs once every 2^n clocks. The first tick comes 2^n clocks after the enabling write. A code above 8 acts as 8, but it reads back as it was written.
- R5: On a tick where the count equals the terminal value, status bit 0 is set. In periodic mode the count returns to 0 and counting goes on.
- R6: In single-shot mode, that same match clears the run bit, and the count holds at the terminal value.
- R7: Writing 1 to status bit 0 clears it. Writing 0 leaves it unchanged.
- R8: Interrupt line c is high exactly while that channel's status bit 0 and interrupt enable are both set. It stays high until the status bit is cleared, even after the channel stops.
- R9: The two channels are independent. Activity on one channel never changes the other channel's registers.
- R10: The count register is read-only. Writes to it are ignored.
- R11: After reset, every register reads 0 and both interrupt lines are low. A channel whose run bit is clear keeps its count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock shared by both channels |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 9 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from bus_addr |
| tmr_irq | output | 2 | Level interrupt, one bit per channel |

## Verification
Corruption in the divider state shows up at the ports as a count that falls behind or runs ahead of 2^n clocks per step. Sampling a channel exactly one clock before and one clock after an expected step exposes it within a single tick period. A wrong match or reload decision shows up one clock after the terminal tick as one of three symptoms: a count that failed to wrap, a status flag that stayed low, or a run bit that did not clear. Leakage between channels shows up as a parked channel whose count or terminal value has moved when it is read back after the other channel has been exercised.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // register index inside one channel window (address bits 3:2)
    typedef enum logic [1:0] {
        RSEL_CTRL  = 2'd0,
        RSEL_STAT  = 2'd1,
        RSEL_TERM  = 2'd2,
        RSEL_COUNT = 2'd3
    } tmr_rsel_e;

    // control field bit positions (fixed by the register layout)
    localparam int unsigned CTRL_IE_BIT   = 8;
    localparam int unsigned CTRL_RUN_BIT  = 5;
    localparam int unsigned CTRL_SHOT_BIT = 4;
    localparam int unsigned CTRL_DIV_LSB  = 0;
    localparam int unsigned DIV_CODE_W    = 4;

    // window geometry
    localparam int unsigned WIN_SHIFT = 7;   // 0x80 stride

    typedef struct packed {
        logic                  ie;
        logic                  run;
        logic                  shot;
        logic [DIV_CODE_W-1:0] div;
    } tmr_ctrl_t;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
#(
    parameter int unsigned MAX_SHIFT = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run_i,
    input  logic                  restart_i,
    input  logic [DIV_CODE_W-1:0] code_i,
    output logic                  tick_o
);

    localparam int unsigned PRE_W = (MAX_SHIFT < 1) ? 1 : MAX_SHIFT;

    typedef struct packed {
        logic [PRE_W-1:0] acc;
    } pre_state_t;

    pre_state_t             st_d, st_q;
    logic [DIV_CODE_W-1:0]  eff_code;
    logic [PRE_W-1:0]       limit;

    always_comb begin
        if (int'(code_i) > int'(MAX_SHIFT)) begin
            eff_code = DIV_CODE_W'(MAX_SHIFT);
        end else begin
            eff_code = code_i;
        end
        limit  = {PRE_W{1'b1}} >> (PRE_W - int'(eff_code));
        tick_o = run_i && (st_q.acc == limit);

        st_d = st_q;
        if (restart_i) begin
            st_d.acc = '0;
        end else if (run_i) begin
            if (tick_o) begin
                st_d.acc = '0;
            end else begin
                st_d.acc = st_q.acc + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // a non-unity divider never ticks on two consecutive clocks
    assert_tick_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && eff_code != '0 && !restart_i) |=> !tick_o);

    // a restart always brings the divider back to its origin
    assert_restart_origin_R3: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (st_q.acc == '0));

endmodule

// File: rtl/tmr_decode.sv
module tmr_decode
    import tmr_pkg::*;
#(
    parameter int unsigned ADDR_W = 9,
    parameter int unsigned NUM_CH = 2,
    parameter int unsigned CH_W   = 1
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o,
    output logic [CH_W-1:0]   ch_o,
    output tmr_rsel_e         rsel_o
);

    localparam int unsigned BLK_W = ADDR_W - WIN_SHIFT;

    logic [BLK_W-1:0] blk;
    logic [WIN_SHIFT-1:0] off;

    always_comb begin
        blk    = addr_i[ADDR_W-1:WIN_SHIFT];
        off    = addr_i[WIN_SHIFT-1:0];
        rsel_o = tmr_rsel_e'(off[3:2]);
        hit_o  = (int'(blk) >= 1) && (int'(blk) <= int'(NUM_CH))
                 && (off[WIN_SHIFT-1:4] == '0) && (off[1:0] == 2'b00);
        if (hit_o) begin
            ch_o = CH_W'(int'(blk) - 1);
        end else begin
            ch_o = '0;
        end
    end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned CNT_W     = 16,
    parameter int unsigned MAX_SHIFT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  tmr_rsel_e         rsel_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o
);

    typedef struct packed {
        tmr_ctrl_t        ctrl;
        logic             pend;
        logic [CNT_W-1:0] term;
        logic [CNT_W-1:0] count;
    } ch_state_t;

    ch_state_t st_d, st_q;
    logic      tick;
    logic      restart;
    logic      ctrl_wr;
    logic      stat_wr;
    logic      term_wr;
    logic      at_term;

    always_comb begin
        ctrl_wr = wr_i && (rsel_i == RSEL_CTRL);
        stat_wr = wr_i && (rsel_i == RSEL_STAT);
        term_wr = wr_i && (rsel_i == RSEL_TERM);
        restart = ctrl_wr && !st_q.ctrl.run && wdata_i[CTRL_RUN_BIT];
        at_term = (st_q.count == st_q.term);
    end

    tmr_prescaler #(
        .MAX_SHIFT (MAX_SHIFT)
    ) i_prescaler (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (st_q.ctrl.run),
        .restart_i (restart),
        .code_i    (st_q.ctrl.div),
        .tick_o    (tick)
    );

    always_comb begin
        st_d = st_q;

        // counting engine
        if (st_q.ctrl.run && tick) begin
            if (at_term) begin
                if (st_q.ctrl.shot) begin
                    st_d.ctrl.run = 1'b0;
                end else begin
                    st_d.count = '0;
                end
            end else begin
                st_d.count = st_q.count + 1'b1;
            end
        end

        // acknowledge, then a same-cycle match wins
        if (stat_wr && wdata_i[0]) begin
            st_d.pend = 1'b0;
        end
        if (st_q.ctrl.run && tick && at_term) begin
            st_d.pend = 1'b1;
        end

        // software writes
        if (ctrl_wr) begin
            st_d.ctrl.ie   = wdata_i[CTRL_IE_BIT];
            st_d.ctrl.run  = wdata_i[CTRL_RUN_BIT];
            st_d.ctrl.shot = wdata_i[CTRL_SHOT_BIT];
            st_d.ctrl.div  = wdata_i[CTRL_DIV_LSB +: DIV_CODE_W];
        end
        if (term_wr) begin
            st_d.term = wdata_i[CNT_W-1:0];
        end
        if (restart) begin
            st_d.count = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        unique case (rsel_i)
            RSEL_CTRL: begin
                rdata_o[CTRL_IE_BIT]                    = st_q.ctrl.ie;
                rdata_o[CTRL_RUN_BIT]                   = st_q.ctrl.run;
                rdata_o[CTRL_SHOT_BIT]                  = st_q.ctrl.shot;
                rdata_o[CTRL_DIV_LSB +: DIV_CODE_W]     = st_q.ctrl.div;
            end
            RSEL_STAT:  rdata_o[0] = st_q.pend;
            RSEL_TERM:  rdata_o[CNT_W-1:0] = st_q.term;
            RSEL_COUNT: rdata_o[CNT_W-1:0] = st_q.count;
            default:    rdata_o = '0;
        endcase
        irq_o = st_q.pend && st_q.ctrl.ie;
    end

    // counting step while running below the terminal value
    assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl.run && tick && !at_term && !ctrl_wr)
        |=> (st_q.count == $past(st_q.count) + 1'b1));

    // periodic wrap at the terminal value latches the flag
    assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl.run && !st_q.ctrl.shot && tick && at_term && !ctrl_wr)
        |=> (st_q.count == '0 && st_q.pend));

    // single-shot stop at the terminal value
    assert_shot_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl.run && st_q.ctrl.shot && tick && at_term && !ctrl_wr)
        |=> (!st_q.ctrl.run && st_q.pend && $stable(st_q.count)));

    // an idle channel keeps its count
    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.ctrl.run && !ctrl_wr) |=> $stable(st_q.count));

    // pending flag with interrupts enabled keeps the line up
    assert_irq_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && st_q.ctrl.ie && !stat_wr && !ctrl_wr) |=> irq_o);

    // writing zero to the status never clears it
    assert_w0_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && !wdata_i[0] && st_q.pend) |=> st_q.pend);

endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
    import tmr_pkg::*;
#(
    parameter int unsigned ADDR_W    = 9,
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned CNT_W     = 16,
    parameter int unsigned NUM_CH    = 2,
    parameter int unsigned MAX_SHIFT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] tmr_irq
);

    localparam int unsigned CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic              hit;
    logic [CH_W-1:0]   ch_idx;
    tmr_rsel_e         rsel;
    logic [DATA_W-1:0] ch_rdata [NUM_CH];
    logic [NUM_CH-1:0] ch_sel;

    tmr_decode #(
        .ADDR_W (ADDR_W),
        .NUM_CH (NUM_CH),
        .CH_W   (CH_W)
    ) i_decode (
        .addr_i (bus_addr),
        .hit_o  (hit),
        .ch_o   (ch_idx),
        .rsel_o (rsel)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign ch_sel[c] = hit && (int'(ch_idx) == c);

        tmr_channel #(
            .DATA_W    (DATA_W),
            .CNT_W     (CNT_W),
            .MAX_SHIFT (MAX_SHIFT)
        ) i_channel (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_i    (bus_wr && ch_sel[c]),
            .rsel_i  (rsel),
            .wdata_i (bus_wdata),
            .rdata_o (ch_rdata[c]),
            .irq_o   (tmr_irq[c])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (ch_sel[c]) begin
                bus_rdata = bus_rdata | ch_rdata[c];
            end
        end
    end

    // at most one channel window answers an address
    assert_one_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_sel));

    // unmapped addresses read as zero
    assert_unmapped_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (bus_rdata == '0));

endmodule

// File: tb/test_dual_interval_timer.sv
module test_dual_interval_timer;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [1:0]  tmr_irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_interval_timer i_dual_interval_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tmr_irq   (tmr_irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        for (int c = 0; c < 2; c++) begin
            for (int r = 0; r < 4; r++) begin
                rd(9'(12'h80 * (c + 1) + r * 4), v);
                chk("R11 reset register", v, 16'h0);
            end
        end
        chk("R11 reset irq", {14'b0, tmr_irq}, 16'h0);
    endtask

    task automatic t_ctrl_fields();
        logic [15:0] v;
        wr(9'h100, 16'hFFFF);
        rd(9'h100, v);
        chk("R2 control readback", v, 16'h013F);
        wr(9'h100, 16'h0000);
        rd(9'h100, v);
        chk("R2 control cleared", v, 16'h0000);
    endtask

    task automatic t_periodic();
        logic [15:0] v;
        wr(9'h088, 16'd10);
        wr(9'h080, 16'h0020);
        rd(9'h08C, v); chk("R3 count starts at zero", v, 16'd0);
        wait_clk(5);
        rd(9'h08C, v); chk("R3 count step", v, 16'd5);
        wait_clk(5);
        rd(9'h08C, v); chk("R5 count at terminal", v, 16'd10);
        rd(9'h084, v); chk("R5 no flag before match", v, 16'd0);
        wait_clk(1);
        rd(9'h08C, v); chk("R5 wrap to zero", v, 16'd0);
        rd(9'h084, v); chk("R5 flag on match", v, 16'd1);
        chk("R8 irq low while disabled", {14'b0, tmr_irq}, 16'h0);
        wait_clk(3);
        rd(9'h08C, v); chk("R5 keeps counting", v, 16'd3);
        wr(9'h084, 16'h0000);
        rd(9'h084, v); chk("R7 write zero keeps flag", v, 16'd1);
        wr(9'h084, 16'h0001);
        rd(9'h084, v); chk("R7 write one clears", v, 16'd0);
    endtask

    task automatic t_irq();
        logic [15:0] v;
        wr(9'h080, 16'h0120);
        wait_clk(20);
        chk("R8 irq raised", {14'b0, tmr_irq}, 16'h1);
        wr(9'h080, 16'h0100);
        wait_clk(15);
        chk("R8 irq level held", {14'b0, tmr_irq}, 16'h1);
        wr(9'h084, 16'h0001);
        chk("R8 irq cleared", {14'b0, tmr_irq}, 16'h0);
        rd(9'h084, v); chk("R7 flag cleared", v, 16'd0);
    endtask

    task automatic t_oneshot();
        logic [15:0] v;
        wr(9'h088, 16'd4);
        wr(9'h080, 16'h0130);
        wait_clk(4);
        rd(9'h08C, v); chk("R6 count at terminal", v, 16'd4);
        chk("R6 irq not yet", {14'b0, tmr_irq}, 16'h0);
        wait_clk(1);
        rd(9'h080, v); chk("R6 run bit cleared", v, 16'h0110);
        rd(9'h08C, v); chk("R6 count held", v, 16'd4);
        chk("R8 irq on single shot", {14'b0, tmr_irq}, 16'h1);
        wait_clk(5);
        rd(9'h08C, v); chk("R11 stopped count holds", v, 16'd4);
        wr(9'h08C, 16'h0055);
        rd(9'h08C, v); chk("R10 count write ignored", v, 16'd4);
        wr(9'h084, 16'h0001);
        wr(9'h080, 16'h0130);
        rd(9'h08C, v); chk("R3 restart clears count", v, 16'd0);
        wait_clk(5);
        wr(9'h080, 16'h0000);
        wr(9'h084, 16'h0001);
        rd(9'h08C, v); chk("R6 second shot stops", v, 16'd4);
    endtask

    task automatic t_prescale();
        logic [15:0] v;
        wr(9'h108, 16'hFFFF);
        wr(9'h100, 16'h0023);
        wait_clk(7);
        rd(9'h10C, v); chk("R4 no tick before 8 clocks", v, 16'd0);
        wait_clk(1);
        rd(9'h10C, v); chk("R4 first tick at 8", v, 16'd1);
        wait_clk(15);
        rd(9'h10C, v); chk("R4 div8 at 23", v, 16'd2);
        wait_clk(1);
        rd(9'h10C, v); chk("R4 div8 at 24", v, 16'd3);
        rd(9'h08C, v); chk("R9 other count untouched", v, 16'd4);
        rd(9'h088, v); chk("R9 other terminal untouched", v, 16'd4);
        wr(9'h100, 16'h0000);
        wr(9'h100, 16'h002C);
        rd(9'h100, v); chk("R4 code readback", v, 16'h002C);
        wait_clk(255);
        rd(9'h10C, v); chk("R4 clamped code at 255", v, 16'd0);
        wait_clk(1);
        rd(9'h10C, v); chk("R4 clamped code at 256", v, 16'd1);
        wr(9'h100, 16'h0000);
    endtask

    task automatic t_unmapped();
        logic [15:0] v;
        wr(9'h1FC, 16'hFFFF);
        wr(9'h090, 16'hFFFF);
        wr(9'h082, 16'hFFFF);
        rd(9'h1FC, v); chk("R1 unmapped high", v, 16'h0);
        rd(9'h000, v); chk("R1 unmapped low", v, 16'h0);
        rd(9'h090, v); chk("R1 hole in window", v, 16'h0);
        rd(9'h082, v); chk("R1 misaligned", v, 16'h0);
        rd(9'h088, v); chk("R1 terminal untouched", v, 16'd4);
        rd(9'h080, v); chk("R1 control untouched", v, 16'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(1);
        t_reset();
        t_ctrl_fields();
        t_periodic();
        t_irq();
        wr(9'h080, 16'h0000);
        t_oneshot();
        t_prescale();
        t_unmapped();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule